// File: doc/BRIEF.md
# Prioritized Interrupt Dispatcher

This block is the interrupt entry logic of a small processor with five interrupt sources. It keeps a 5-bit pending-request register and a 5-bit enable register. It also holds a master enable, a delayed-enable latch and a halt flag. The core pulses `boundary` at each instruction boundary. On that pulse the dispatcher decides whether to take an interrupt. When it does, it picks the lowest-numbered pending and enabled source and clears that request bit. It drops both enables and emits a one-cycle `take` pulse. The pulse carries the vector address and the program counter to be pushed onto the stack.

The core reports instruction effects as single-cycle strobes: `ei`, `di`, `reti` and `halt_set`. Sources raise request bits through `src_req`. Software loads the enable register through `en_we`/`en_wdata`. Stack memory, the program counter datapath and the sources sit outside the block. `take` also serves as the push request for `push_pc`.

When a boundary coincides with instruction strobes, the boundary decision is made first. The strobes then apply, in this order: `ei`, `reti`, `halt_set`, `di`. The last one listed wins.

Top module: `irq_dispatch`

## Requirements
- R1: An interrupt is taken only on a cycle with `boundary` high, master enable set and a nonzero AND of `req_q` and `en_q`. In any other case `take` stays low in the following cycle.
- R2: When several enabled requests are pending, bit 0 has the highest priority and the lowest-numbered bit is chosen.
- R3: Taking source n raises `take` for exactly one cycle, starting the cycle after the boundary. In that cycle `vector` = 0x0040 + 8·n and `push_pc` = the `pc_in` value present at the boundary.
- R4: Taking source n clears request bit n, the master enable and the delayed-enable latch.
- R5: `ei` sets only the delayed-enable latch. The master enable copies the latch at the next boundary, after that boundary's interrupt decision. So after `ei` the earliest take is at the second boundary.
- R6: `di` clears the master enable, the delayed-enable latch and the halt flag in the next cycle.
- R7: `reti` sets the master enable and the delayed-enable latch in the next cycle.
- R8: While `halted` is high and the master enable is set, a pending enabled request clears `halted` in the next cycle. With the master enable clear, `halted` stays high.
- R9: If a source sets a request bit in the same cycle that a take clears another bit, both updates take effect.
- R10: After reset `take`, `ime`, `halted`, `req_q` and `en_q` are zero. `en_we` loads `en_wdata` into `en_q` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| ei | input | 1 | Enable-interrupts instruction strobe |
| di | input | 1 | Disable-interrupts instruction strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| halt_set | input | 1 | Halt instruction strobe |
| src_req | input | 5 | Per-source request set pulses |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 5 | Enable register write data |
| pc_in | input | 16 | Current program counter |
| take | output | 1 | One-cycle interrupt-taken pulse; also the push request |
| vector | output | 16 | Handler address, valid with take |
| push_pc | output | 16 | Program counter to push, valid with take |
| ime | output | 1 | Master interrupt enable |
| halted | output | 1 | Halt flag |
| req_q | output | 5 | Pending request register |
| en_q | output | 5 | Enable register |

## Verification
The directed part exercises several request patterns:
- two pending bits (0x0C), which shows that priority goes to the lower bit;
- a single pending bit raised together with a new one, which separates the clear of one bit from the set of another;
- a request whose enable bit is clear, which shows that a masked source is never taken.

The `ei` sequence with back-to-back boundaries tells the one-boundary delay apart from an immediate enable. Halt is tried with the master enable both clear and set, which separates a wake gated by the enable from an unconditional one. A long random phase then compares every output against a behavioural model in every cycle, including coinciding strobes.

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int NSRC = 5,
  parameter int AW = 16,
  parameter logic [15:0] VEC_BASE = 16'h0040,
  parameter int VEC_SHIFT = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            boundary,
  input  logic            ei,
  input  logic            di,
  input  logic            reti,
  input  logic            halt_set,
  input  logic [NSRC-1:0] src_req,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_wdata,
  input  logic [AW-1:0]   pc_in,
  output logic            take,
  output logic [AW-1:0]   vector,
  output logic [AW-1:0]   push_pc,
  output logic            ime,
  output logic            halted,
  output logic [NSRC-1:0] req_q,
  output logic [NSRC-1:0] en_q
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic            ima;
  logic [NSRC-1:0] pend, clr;
  logic [IW-1:0]   sel;
  logic            fire;

  assign pend = req_q & en_q;
  assign fire = boundary && ime && (|pend);

  always_comb begin
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pend[i]) sel = IW'(i);
  end

  assign clr = fire ? (NSRC'(1) << sel) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= '0;
      en_q    <= '0;
      ime     <= 1'b0;
      ima     <= 1'b0;
      halted  <= 1'b0;
      take    <= 1'b0;
      vector  <= '0;
      push_pc <= '0;
    end else begin
      req_q <= (req_q & ~clr) | src_req;
      if (en_we) en_q <= en_wdata;
      take <= fire;
      if (fire) begin
        vector  <= AW'(VEC_BASE) + (AW'(sel) << VEC_SHIFT);
        push_pc <= pc_in;
      end

      if (di) begin
        ime <= 1'b0;
        ima <= 1'b0;
      end else if (reti) begin
        ime <= 1'b1;
        ima <= 1'b1;
      end else begin
        if (boundary) ime <= fire ? 1'b0 : ima;
        if (ei) ima <= 1'b1;
        else if (fire) ima <= 1'b0;
      end

      if (di) halted <= 1'b0;
      else if (halt_set) halted <= 1'b1;
      else if (fire || (halted && ime && (|pend))) halted <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        di,
  input logic        reti,
  input logic        take,
  input logic [15:0] vector,
  input logic        ime,
  input logic        halted
);
  // R1
  take_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($past(boundary) && $past(ime)));

  // R3
  vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (vector[2:0] == 3'd0 && vector >= 16'h0040 && vector <= 16'h0060));

  // R4
  take_drops_ime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !$past(reti)) |-> !ime);

  // R6
  di_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    di |=> (!ime && !halted));

  // R7
  reti_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !di) |=> ime);
endmodule

bind irq_dispatch irq_dispatch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .di(di), .reti(reti),
  .take(take), .vector(vector), .ime(ime), .halted(halted)
);

// File: tb/tb_irq_dispatch.sv
module tb_irq_dispatch;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic boundary = 0, ei = 0, di = 0, reti = 0, halt_set = 0, en_we = 0;
  logic [4:0] src_req = 0, en_wdata = 0;
  logic [15:0] pc_in = 0;
  logic take, ime, halted;
  logic [15:0] vector, push_pc;
  logic [4:0] req_q, en_q;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_req, m_en, m_vec, m_push;
  bit m_ime, m_ima, m_halt, m_take;

  irq_dispatch dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic tick();
    int pend, nreq, win;
    bit fire, nime, nima, nhalt;
    pend = m_req & m_en;
    fire = boundary && m_ime && pend != 0;
    win = -1;
    for (int i = 0; i < 5; i++) if (win < 0 && pend[i]) win = i;
    nreq = m_req;
    if (fire) nreq = nreq & ~(1 << win);
    nreq = nreq | src_req;
    nime = m_ime; nima = m_ima; nhalt = m_halt;
    if (boundary) nime = fire ? 0 : m_ima;
    if (fire) begin nima = 0; nhalt = 0; end
    if (m_halt && m_ime && pend != 0) nhalt = 0;
    if (ei) nima = 1;
    if (reti) begin nime = 1; nima = 1; end
    if (halt_set) nhalt = 1;
    if (di) begin nime = 0; nima = 0; nhalt = 0; end
    @(posedge clk);
    if (!rst_n) begin
      m_req = 0; m_en = 0; m_ime = 0; m_ima = 0; m_halt = 0; m_take = 0;
    end else begin
      m_req = nreq;
      if (en_we) m_en = en_wdata;
      m_ime = nime; m_ima = nima; m_halt = nhalt; m_take = fire;
      if (fire) begin m_vec = 'h40 + 8 * win; m_push = pc_in; end
    end
    @(negedge clk);
    if (rst_n) begin
      chk(take == m_take, "R1", "take", take, m_take);
      if (m_take) begin
        chk(vector == m_vec[15:0], "R3", "vector", vector, m_vec);
        chk(push_pc == m_push[15:0], "R3", "push_pc", push_pc, m_push);
      end
      chk(ime == m_ime, "R5", "ime", ime, m_ime);
      chk(halted == m_halt, "R8", "halted", halted, m_halt);
      chk(req_q == m_req[4:0], "R9", "req_q", req_q, m_req);
      chk(en_q == m_en[4:0], "R10", "en_q", en_q, m_en);
    end
    boundary = 0; ei = 0; di = 0; reti = 0; halt_set = 0; en_we = 0; src_req = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    chk(take == 0 && ime == 0 && halted == 0 && req_q == 0 && en_q == 0,
        "R10", "reset state", {take, ime, halted, req_q, en_q}, 0);

    en_we = 1; en_wdata = 5'h1F; src_req = 5'h0C; tick();
    boundary = 1; tick();
    chk(take == 0, "R1", "no take with ime clear", take, 0);

    reti = 1; tick();
    chk(ime == 1, "R7", "reti sets ime", ime, 1);

    boundary = 1; pc_in = 16'h1234; tick();
    chk(take == 1 && vector == 16'h0050, "R2", "lowest pending wins", vector, 16'h0050);
    chk(push_pc == 16'h1234, "R3", "pushed pc", push_pc, 16'h1234);
    chk(req_q == 5'h08 && ime == 0, "R4", "taken bit and ime cleared", {ime, req_q}, 5'h08);
    tick();
    chk(take == 0, "R3", "take one cycle", take, 0);

    ei = 1; tick();
    chk(ime == 0, "R5", "ei does not set ime", ime, 0);
    boundary = 1; tick();
    chk(take == 0 && ime == 1, "R5", "first boundary after ei", {take, ime}, 1);
    boundary = 1; tick();
    chk(take == 1 && vector == 16'h0058, "R5", "take at second boundary", vector, 16'h0058);

    reti = 1; tick();
    halt_set = 1; tick();
    di = 1; tick();
    chk(ime == 0 && halted == 0, "R6", "di clears", {ime, halted}, 0);

    src_req = 5'h01; tick();
    reti = 1; tick();
    boundary = 1; src_req = 5'h10; tick();
    chk(take == 1 && vector == 16'h0040 && req_q == 5'h10, "R9", "set and clear together",
        req_q, 5'h10);

    halt_set = 1; tick();
    src_req = 5'h02; tick();
    chk(halted == 1, "R8", "halt kept with ime clear", halted, 1);
    reti = 1; tick();
    tick();
    chk(halted == 0, "R8", "halt woken", halted, 0);

    di = 1; en_we = 1; en_wdata = 5'h00; tick();
    reti = 1; tick();
    boundary = 1; tick();
    chk(take == 0 && req_q == 5'h12, "R1", "masked request not taken", req_q, 5'h12);

    for (int k = 0; k < 3000; k++) begin
      boundary = ($urandom % 3) == 0;
      ei = ($urandom % 10) == 0;
      di = ($urandom % 25) == 0;
      reti = ($urandom % 20) == 0;
      halt_set = ($urandom % 30) == 0;
      src_req = (($urandom % 4) == 0) ? 5'($urandom) : 5'h0;
      en_we = ($urandom % 40) == 0;
      en_wdata = 5'($urandom);
      pc_in = 16'($urandom);
      tick();
    end
    finish_run();
  end
endmodule